// File: doc/BRIEF.md
# Clock Register Bank with Snapshot Halt

This block sits at the top eight byte addresses of a host memory space. It holds one control byte and seven clock bytes. A free-running calendar counter outside the block supplies the seven clock bytes. The host reads and writes all eight bytes as ordinary memory through a simple synchronous strobe bus.

An internal one-second divider refreshes the seven clock bytes from the counter together, in one clock edge. The refresh is skipped while the host holds the halt bit of the control byte at 1, so the host can read a coherent time that does not change under it. When the host clears the halt bit, the divider restarts. The first refresh then lands exactly one second later.

A host write to a clock byte also issues a one-cycle load request, so the counter can adopt the new value. The control bits other than the halt bit are passed on unchanged to the timebase as a calibration setting.

Top module: `clock_snapshot_window`

## Requirements
- R1: While `rst_n` is low at a clock edge, the control byte and all clock bytes clear to 0. `bus_rdata`, `bus_rvalid`, `load_req`, `load_idx`, `load_data` and `calib` are 0 after that edge.
- R2: The window is selected only when address bits [ADDR_W-1:3] are all ones. Any other address has these effects:
  - a write changes no byte and raises no load request;
  - a read returns 0.
- R3: A read strobe (`bus_cs`=1, `bus_we`=0) at an edge gives `bus_rvalid`=1 and `bus_rdata` after that edge. The byte returned depends on the address offset:
  - offset 0 returns the control byte;
  - offset k (1..7) returns clock byte k.
  - Clock byte k is fed from `cnt_time[8k-1:8k-8]`: 1 second, 2 minute, 3 hour, 4 day, 5 date, 6 month, 7 year.
- R4: A write to offset 1..7 stores `bus_wdata` in that clock byte, and a later read returns it.
- R5: After the edge of a clock-byte write, `load_req` is 1 for exactly one cycle. During that cycle `load_idx` holds the offset and `load_data` holds the written byte. Control writes never raise `load_req`.
- R6: While not halted, all seven clock bytes copy `cnt_time` at one edge once every SEC_CYCLES cycles.
- R7: While control bit 6 (halt) is 1, no refresh happens. The clock bytes keep the values they held when the halt took effect.
- R8: A write that sets the halt bit at the same edge as a due refresh does not cancel that refresh.
- R9: A control write that clears a set halt bit restarts the divider. The next refresh happens at the edge SEC_CYCLES cycles after that write, and none happens earlier.
- R10: After any control write, `calib` equals {bit 7, bits 5..0} of the written byte.
- R11: If a host clock-byte write coincides with a refresh, the written offset keeps the host value. The other six bytes take the counter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| cnt_time | input | 56 | Calendar counter, seven bytes, second in the low byte |
| load_req | output | 1 | Pulse: host wrote a clock byte |
| load_idx | output | 3 | Offset of the written clock byte |
| load_data | output | 8 | Value written |
| calib | output | 7 | Calibration bits of the control byte |

## Verification
Every result appears one edge after the stimulus that causes it:
- read data and `bus_rvalid` after the read edge;
- `load_req` and `calib` after the write edge.

A refresh lands at the edge SEC_CYCLES cycles after a halt-clearing write. A read issued at that same edge still returns the old bytes, so the new values are only read from the following edge on.

The bench counts edges from a recorded halt-clear edge and places each read just before or after the refresh edge. The driver queues the expected bytes, and a monitor compares them on `bus_rvalid` at the falling edge.

// File: rtl/clkwin_pkg.sv
// Package: shared constants for the clock register window.
// Assumes byte-wide host data and seven clock bytes above one control byte.
package clkwin_pkg;
    localparam int BYTE_W   = 8;
    localparam int NUM_CLK  = 7;
    localparam int OFF_W    = 3;
    localparam int HALT_BIT = 6;
    localparam int TIME_W   = NUM_CLK * BYTE_W;
    localparam int CAL_W    = BYTE_W - 1;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [OFF_W-1:0]  off_t;
endpackage

// File: rtl/clkwin_divider.sv
// Module: one-second divider producing a single-cycle refresh tick.
// Assumes SEC_CYCLES >= 2; restart forces the phase to zero so the next tick
// comes SEC_CYCLES edges after the restarting edge.
module clkwin_divider #(
    parameter int SEC_CYCLES = 32768,
    localparam int CNT_W = (SEC_CYCLES > 2) ? $clog2(SEC_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SEC_CYCLES - 1);

    logic [CNT_W-1:0] count_q;

    assign tick = (count_q == LAST);

    // Purpose: advance the phase counter, wrap at LAST, zero on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    // R9: a restart is never followed directly by a tick
    a_r9_restart_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);
    // R6: the phase never leaves its range
    a_r6_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= LAST);
endmodule

// File: rtl/clkwin_decode.sv
// Module: address decode of the top-eight-byte window into access strobes.
// Assumes ADDR_W > 3; the window is every address whose upper bits are all ones.
module clkwin_decode
    import clkwin_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_ctrl,
    output logic              wr_clk,
    output logic              rd_en,
    output logic              rd_hit,
    output off_t              offset
);
    logic in_window;

    // Purpose: classify the current access by window, direction and offset.
    always_comb begin
        in_window = &addr[ADDR_W-1:OFF_W];
        offset    = addr[OFF_W-1:0];
        wr_ctrl   = cs && we && in_window && (offset == '0);
        wr_clk    = cs && we && in_window && (offset != '0);
        rd_en     = cs && !we;
        rd_hit    = rd_en && in_window;
    end
endmodule

// File: rtl/clkwin_bank.sv
// Module: control byte plus seven clock bytes with halted/unhalted refresh.
// Assumes at most one host write per cycle; a host write to a clock byte takes
// priority over a refresh of that same byte.
module clkwin_bank
    import clkwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_clk,
    input  off_t              offset,
    input  byte_t             wdata,
    input  logic              tick,
    input  logic [TIME_W-1:0] cnt_time,
    output byte_t             ctrl_q,
    output logic [TIME_W-1:0] clk_bytes,
    output logic              restart
);
    logic halt_q;
    logic do_refresh;

    assign halt_q     = ctrl_q[HALT_BIT];
    // Halt is judged on the stored bit, so a same-edge halt write lets a due refresh finish.
    assign do_refresh = tick && !halt_q;
    assign restart    = wr_ctrl && halt_q && !wdata[HALT_BIT];

    // Purpose: hold the control byte written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wdata;
        end
    end

    for (genvar k = 1; k <= NUM_CLK; k++) begin : g_clk
        // Purpose: one clock byte, host write first, else counter refresh.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                clk_bytes[BYTE_W*(k-1) +: BYTE_W] <= '0;
            end else if (wr_clk && (offset == OFF_W'(k))) begin
                clk_bytes[BYTE_W*(k-1) +: BYTE_W] <= wdata;
            end else if (do_refresh) begin
                clk_bytes[BYTE_W*(k-1) +: BYTE_W] <= cnt_time[BYTE_W*(k-1) +: BYTE_W];
            end
        end
    end

    // R7: halted and no host write, the snapshot does not move
    a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q && !wr_clk) |=> $stable(clk_bytes));
    // R6: an unhalted tick copies all seven counter bytes at once
    a_r6_refresh_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !halt_q && !wr_clk) |=> (clk_bytes == $past(cnt_time)));
    // R8: a halt written at a due tick still lets the refresh land
    a_r8_halt_late: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !halt_q && wr_ctrl && wdata[HALT_BIT] && !wr_clk)
            |=> (clk_bytes == $past(cnt_time)) && halt_q);
endmodule

// File: rtl/clock_snapshot_window.sv
// Module: top of the clock register window; host read port, load request
// output and calibration output around the decoder, divider and bank.
// Assumes a synchronous host bus issuing at most one access per cycle.
module clock_snapshot_window
    import clkwin_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int SEC_CYCLES = 32768
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_cs,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    input  logic [TIME_W-1:0]   cnt_time,
    output logic                load_req,
    output logic [OFF_W-1:0]    load_idx,
    output logic [BYTE_W-1:0]   load_data,
    output logic [CAL_W-1:0]    calib
);
    logic              wr_ctrl, wr_clk, rd_en, rd_hit, tick, restart;
    off_t              offset;
    byte_t             ctrl_q;
    logic [TIME_W-1:0] clk_bytes;
    byte_t             rd_mux;

    clkwin_decode #(.ADDR_W(ADDR_W)) u_dec (
        .cs(bus_cs), .we(bus_we), .addr(bus_addr),
        .wr_ctrl(wr_ctrl), .wr_clk(wr_clk), .rd_en(rd_en),
        .rd_hit(rd_hit), .offset(offset)
    );

    clkwin_divider #(.SEC_CYCLES(SEC_CYCLES)) u_div (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
    );

    clkwin_bank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_clk(wr_clk),
        .offset(offset), .wdata(bus_wdata), .tick(tick), .cnt_time(cnt_time),
        .ctrl_q(ctrl_q), .clk_bytes(clk_bytes), .restart(restart)
    );

    // Purpose: select the addressed byte of the window.
    always_comb begin
        rd_mux = ctrl_q;
        for (int k = 1; k <= NUM_CLK; k++) begin
            if (offset == OFF_W'(k)) begin
                rd_mux = clk_bytes[BYTE_W*(k-1) +: BYTE_W];
            end
        end
    end

    // Purpose: register read data; out-of-window reads return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_en;
            bus_rdata  <= rd_hit ? rd_mux : '0;
        end
    end

    // Purpose: announce host clock-byte writes to the counter for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_req  <= 1'b0;
            load_idx  <= '0;
            load_data <= '0;
        end else begin
            load_req <= wr_clk;
            if (wr_clk) begin
                load_idx  <= offset;
                load_data <= bus_wdata;
            end
        end
    end

    assign calib = {ctrl_q[BYTE_W-1], ctrl_q[HALT_BIT-1:0]};

    // R5: each clock-byte write yields one load pulse with its offset and data
    a_r5_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clk |=> load_req && (load_idx == $past(bus_addr[OFF_W-1:0]))
                   && (load_data == $past(bus_wdata)));
    // R5: no load pulse without a clock-byte write
    a_r5_no_spurious_load: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_clk |=> !load_req);
    // R10: calibration output follows the last control write
    a_r10_calib_follow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (calib == {$past(bus_wdata[BYTE_W-1]), $past(bus_wdata[HALT_BIT-1:0])}));
    // R3: read data is valid exactly one cycle after a read strobe
    a_r3_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_we) |=> bus_rvalid);
    // R2: reads outside the window return zero
    a_r2_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_we && !(&bus_addr[ADDR_W-1:OFF_W])) |=> (bus_rdata == '0));
endmodule

// File: tb/tb_clock_snapshot_window.sv
module tb_clock_snapshot_window;
    localparam int AW = 19;
    localparam int N  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_cs = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          bus_rvalid;
    logic [55:0]   cnt_time = '0;
    logic          load_req;
    logic [2:0]    load_idx;
    logic [7:0]    load_data;
    logic [6:0]    calib;

    int checks = 0, failures = 0;
    int cyc = 0;
    int e0, f0;
    byte unsigned exp_q[$];
    string        req_q[$];

    clock_snapshot_window #(.ADDR_W(AW), .SEC_CYCLES(N)) dut (.*);

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare every returned read against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R3 unexpected rvalid", bus_rdata, 0);
            end else begin
                automatic byte unsigned e = exp_q.pop_front();
                automatic string r = req_q.pop_front();
                chk(bus_rdata == e, r, bus_rdata, e);
            end
        end
    end

    function automatic logic [AW-1:0] win(input int off);
        return {{(AW-3){1'b1}}, 3'(off)};
    endfunction

    function automatic byte unsigned tbyte(input logic [55:0] v, input int k);
        return v[8*(k-1) +: 8];
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        bus_cs = 1'b0;
        bus_we = 1'b0;
    endtask

    task automatic idle_to(input int target);
        while (cyc + 1 < target) step();
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
    endtask

    task automatic do_read(input logic [AW-1:0] a, input byte unsigned e, input string r);
        exp_q.push_back(e);
        req_q.push_back(r);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
        step();
    endtask

    localparam logic [55:0] VA = 56'h99_12_31_05_23_59_58;
    localparam logic [55:0] VB = 56'h24_02_29_04_11_22_33;
    localparam logic [55:0] VC = 56'h01_07_04_03_08_09_10;
    localparam logic [55:0] VD = 56'h55_55_55_55_55_55_55;
    localparam logic [55:0] VE = 56'h30_11_15_02_17_45_01;

    initial begin : watchdog
        #1000000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(bus_rdata == 0 && bus_rvalid == 0, "R1 read port", bus_rdata, 0);
        chk(load_req == 0 && load_data == 0, "R1 load", load_req, 0);
        chk(calib == 0, "R1 calib", calib, 0);
        rst_n = 1'b1;
        do_read(win(0), 8'h00, "R1 ctrl after reset");
        do_read(win(7), 8'h00, "R1 year after reset");

        // R7 halt, then counter moves
        do_write(win(0), 8'h40);
        chk(load_req == 0, "R5 ctrl write no load", load_req, 0);
        cnt_time = VA;
        repeat (2 * N) step();
        for (int k = 1; k <= 7; k++) do_read(win(k), 8'h00, "R7 frozen");
        do_read(win(0), 8'h40, "R3 ctrl readback");

        // R9 clear halt: refresh exactly N edges later
        do_write(win(0), 8'h85);
        e0 = cyc;
        chk(calib == 7'h45, "R10 calib", calib, 7'h45);
        idle_to(e0 + N - 1);
        do_read(win(1), 8'h00, "R9 no early refresh");
        do_read(win(2), 8'h00, "R9 read at refresh edge sees old");
        for (int k = 1; k <= 7; k++) do_read(win(k), tbyte(VA, k), "R9 R3 refresh after clear");

        // R6 periodic refresh
        cnt_time = VB;
        idle_to(e0 + 2 * N + 1);
        for (int k = 1; k <= 7; k++) do_read(win(k), tbyte(VB, k), "R6 periodic");

        // R8 halt at the refresh edge
        cnt_time = VC;
        idle_to(e0 + 3 * N);
        do_write(win(0), 8'h40);
        cnt_time = VD;
        idle_to(e0 + 4 * N + 2);
        for (int k = 1; k <= 7; k++) do_read(win(k), tbyte(VC, k), "R8 R7 snapshot");

        // R4 R5 host write of a clock byte
        do_write(win(3), 8'h5A);
        chk(load_req == 1, "R5 load_req", load_req, 1);
        chk(load_idx == 3, "R5 load_idx", load_idx, 3);
        chk(load_data == 8'h5A, "R5 load_data", load_data, 8'h5A);
        step();
        chk(load_req == 0, "R5 single pulse", load_req, 0);
        do_read(win(3), 8'h5A, "R4 write readback");

        // R2 outside the window
        do_write(19'h0_0003, 8'h11);
        chk(load_req == 0, "R2 outside no load", load_req, 0);
        do_write(19'h0_0000, 8'h00);
        chk(calib == 0, "R2 outside ctrl untouched", calib, 0);
        repeat (N + 2) step();
        do_read(win(3), 8'h5A, "R2 byte kept");
        do_read(win(1), tbyte(VC, 1), "R2 halt kept");
        do_read(win(0), 8'h40, "R2 ctrl kept");
        do_read(19'h1_2345, 8'h00, "R2 outside read zero");

        // R11 host write coincides with refresh
        do_write(win(0), 8'h00);
        f0 = cyc;
        chk(calib == 0, "R10 calib cleared", calib, 0);
        cnt_time = VE;
        idle_to(f0 + N);
        do_write(win(2), 8'h77);
        chk(load_req == 1 && load_idx == 2, "R11 R5 load on collide", load_idx, 2);
        for (int k = 1; k <= 7; k++)
            do_read(win(k), (k == 2) ? 8'h77 : tbyte(VE, k), "R11 collide");

        repeat (3) step();
        chk(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule